// File: doc/BRIEF.md
# Delayed Branch Next-PC Unit

This block sits beside the issue stage of a 32-bit RISC core whose control-transfer instructions carry exactly one architectural delay slot. Each time an instruction issues, the block receives the instruction word, its address, the condition flag and the value read from the source register. From these it produces the address of the next instruction to fetch. When a jump or branch issues, the next address is always the delay-slot address. The computed target is held in a register and is applied only when the delay-slot instruction itself issues.

Linking forms ask for general register 11 to be written with the address just after the delay slot. The register-indirect target is captured when the jump issues, before that link write happens. A jump-and-link through r11 therefore still goes to the old r11 value. A control transfer found in a delay slot raises a one-cycle illegal-placement pulse. Its own target and link are discarded, and the earlier branch still completes.

The issue strobe acts as the advance handshake. While it is low the block holds all of its state, so stall cycles between a branch and its delay slot cost nothing.

Top module: `dbr_next_pc`

## Requirements
- R1: While reset is asserted and right after it is released, `next_pc` equals RESET_PC (default 0), and `slot_pending`, `link_we` and `illegal_slot` are all 0.
- R2: An issued instruction that is not a control transfer, outside a delay slot, sets `next_pc` to its PC + 4. It leaves `slot_pending` at 0 and `link_we` at 0.
- R3: Decoding works as follows. When insn[31:30] = 0, insn[29:26] selects the instruction: 0 is an absolute jump, 1 is an absolute jump-and-link, 2 is a PC-relative branch-and-link, 3 is a branch taken when the flag is 0, and 4 is a branch taken when the flag is 1. When insn[29:26] = 5 and insn[25:24] = 0, insn[23:21] = 0 is a jump to register and insn[23:21] = 1 is a jump-and-link to register. Every other encoding is not a control transfer.
- R4: A control transfer issued at PC P, outside a slot, sets `next_pc` to P + 4 and sets `slot_pending`. When the next instruction (the slot) issues, `next_pc` becomes the target if the branch was taken, and the slot PC + 4 otherwise. `slot_pending` then clears.
- R5: The absolute target is {insn[25:0], 2'b00}, zero-extended to the address width.
- R6: The PC-relative target is P plus the sign-extended insn[25:0] shifted left by 2.
- R7: The register-form target is `ra_value` as sampled in the cycle the jump issues. Values of `ra_value` in later cycles do not affect it.
- R8: The flag-0 form is taken only if `issue_flag` is 0 at the branch's issue. The flag-1 form is taken only if it is 1. Flag values in later cycles are ignored.
- R9: During the cycle after a linking form issues, `link_we` is 1 and `link_data` = P + 8. After every other issue, and after stall cycles, `link_we` is 0.
- R10: While `issue_valid` is 0, `next_pc` and `slot_pending` hold their values, whatever the other inputs do.
- R11: A control transfer issued in a delay slot gives `illegal_slot` = 1 for one cycle, with `link_we` = 0. `next_pc` follows the pending branch. The slot instruction's own target is ignored, and `slot_pending` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction issues this cycle (advance) |
| issue_pc | input | ADDR_W | Address of the issuing instruction |
| issue_insn | input | INSN_W | Issuing instruction word |
| issue_flag | input | 1 | Condition flag at issue |
| ra_value | input | ADDR_W | Source register value at issue |
| next_pc | output | ADDR_W | Address of the next instruction to fetch |
| slot_pending | output | 1 | The next issue is a delay slot |
| link_we | output | 1 | Write r11 this cycle |
| link_data | output | ADDR_W | Value for r11 |
| illegal_slot | output | 1 | A control transfer sat in a delay slot |

## Verification
A vector table drives each of the seven transfer kinds. Both conditional forms are run with the flag set and with it clear, which separates the taken and fall-through paths. Negative and large forward displacements show whether the sign extension and adder are right. A displacement of all ones shows whether the absolute form sign-extends when it should zero-extend. In every delay slot the bench flips the flag and changes `ra_value`, so a design that samples these late instead of at the branch's issue is caught. Directed cases cover reset, non-transfer encodings that neighbour real transfer codes, stalls between a branch and its slot, a jump-and-link through r11, and a transfer placed in a slot.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    // Instruction field positions fixed by the instruction encoding
    localparam int CLS_HI  = 31;
    localparam int CLS_LO  = 30;
    localparam int SUB_HI  = 29;
    localparam int SUB_LO  = 26;
    localparam int RF_A_HI = 25;
    localparam int RF_A_LO = 24;
    localparam int RF_B_HI = 23;
    localparam int RF_B_LO = 21;
    localparam int OPC_W   = CLS_HI - RF_B_LO + 1;

    typedef enum logic [2:0] {
        XF_NONE,
        XF_JABS,
        XF_JLABS,
        XF_BLREL,
        XF_BCLR,
        XF_BSET,
        XF_JREG,
        XF_JLREG
    } xfer_e;

    typedef struct packed {
        logic is_xfer;
        logic links;
        logic is_cond;
        logic cond_on_set;
        logic use_reg;
        logic use_rel;
    } dec_t;

endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
    import dbr_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output dec_t             dec
);

    localparam int SH = RF_B_LO;

    logic [1:0] cls;
    logic [3:0] sub;
    logic [1:0] rf_a;
    logic [2:0] rf_b;
    xfer_e      kind;

    assign cls  = opc[CLS_HI-SH:CLS_LO-SH];
    assign sub  = opc[SUB_HI-SH:SUB_LO-SH];
    assign rf_a = opc[RF_A_HI-SH:RF_A_LO-SH];
    assign rf_b = opc[RF_B_HI-SH:RF_B_LO-SH];

    always_comb begin
        kind = XF_NONE;
        if (cls == 2'd0) begin
            unique case (sub)
                4'd0:    kind = XF_JABS;
                4'd1:    kind = XF_JLABS;
                4'd2:    kind = XF_BLREL;
                4'd3:    kind = XF_BCLR;
                4'd4:    kind = XF_BSET;
                4'd5: begin
                    if (rf_a == 2'd0 && rf_b == 3'd0)      kind = XF_JREG;
                    else if (rf_a == 2'd0 && rf_b == 3'd1) kind = XF_JLREG;
                    else                                   kind = XF_NONE;
                end
                default: kind = XF_NONE;
            endcase
        end
    end

    always_comb begin
        dec             = '0;
        dec.is_xfer     = (kind != XF_NONE);
        dec.links       = (kind == XF_JLABS) || (kind == XF_BLREL) || (kind == XF_JLREG);
        dec.is_cond     = (kind == XF_BCLR) || (kind == XF_BSET);
        dec.cond_on_set = (kind == XF_BSET);
        dec.use_reg     = (kind == XF_JREG) || (kind == XF_JLREG);
        dec.use_rel     = (kind == XF_BLREL) || dec.is_cond;
    end

endmodule

// File: rtl/dbr_target.sv
module dbr_target
    import dbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 26
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] ra,
    input  dec_t              dec,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] link_addr
);

    localparam int                SCALED_W = DISP_W + 2;
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(4);

    logic [ADDR_W-1:0] abs_tgt;
    logic [ADDR_W-1:0] rel_off;

    generate
        if (ADDR_W > SCALED_W) begin : g_wide
            assign abs_tgt = {{(ADDR_W-SCALED_W){1'b0}}, disp, 2'b00};
            assign rel_off = {{(ADDR_W-SCALED_W){disp[DISP_W-1]}}, disp, 2'b00};
        end else begin : g_narrow
            logic [SCALED_W-1:0] scaled;
            assign scaled  = {disp, 2'b00};
            assign abs_tgt = scaled[ADDR_W-1:0];
            assign rel_off = scaled[ADDR_W-1:0];
        end
    endgenerate

    assign seq_addr  = pc + STEP;
    assign link_addr = seq_addr + STEP;

    always_comb begin
        if (dec.use_reg)      target = ra;
        else if (dec.use_rel) target = pc + rel_off;
        else                  target = abs_tgt;
    end

endmodule

// File: rtl/dbr_next_pc.sv
module dbr_next_pc
    import dbr_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                INSN_W   = 32,
    parameter int                DISP_W   = 26,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [ADDR_W-1:0] issue_pc,
    input  logic [INSN_W-1:0] issue_insn,
    input  logic              issue_flag,
    input  logic [ADDR_W-1:0] ra_value,
    output logic [ADDR_W-1:0] next_pc,
    output logic              slot_pending,
    output logic              link_we,
    output logic [ADDR_W-1:0] link_data,
    output logic              illegal_slot
);

    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(8);

    typedef struct packed {
        logic [ADDR_W-1:0] next_pc;
        logic [ADDR_W-1:0] pend_target;
        logic              pend_taken;
        logic              slot_pending;
        logic              link_we;
        logic [ADDR_W-1:0] link_data;
        logic              illegal;
    } state_t;

    state_t st_d, st_q;

    dec_t              dec;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] link_addr;
    logic              taken;

    dbr_decode u_decode (
        .opc (issue_insn[CLS_HI:RF_B_LO]),
        .dec (dec)
    );

    dbr_target #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_target (
        .pc        (issue_pc),
        .disp      (issue_insn[DISP_W-1:0]),
        .ra        (ra_value),
        .dec       (dec),
        .target    (target),
        .seq_addr  (seq_addr),
        .link_addr (link_addr)
    );

    assign taken = !dec.is_cond || (issue_flag == dec.cond_on_set);

    always_comb begin
        st_d         = st_q;
        st_d.link_we = 1'b0;
        st_d.illegal = 1'b0;
        if (issue_valid) begin
            if (st_q.slot_pending) begin
                // delay slot issues: apply the held branch outcome
                st_d.slot_pending = 1'b0;
                st_d.next_pc      = st_q.pend_taken ? st_q.pend_target : seq_addr;
                st_d.illegal      = dec.is_xfer;
            end else begin
                st_d.next_pc = seq_addr;
                if (dec.is_xfer) begin
                    st_d.slot_pending = 1'b1;
                    st_d.pend_target  = target;
                    st_d.pend_taken   = taken;
                    st_d.link_we      = dec.links;
                    if (dec.links) st_d.link_data = link_addr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.next_pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_pc      = st_q.next_pc;
    assign slot_pending = st_q.slot_pending;
    assign link_we      = st_q.link_we;
    assign link_data    = st_q.link_data;
    assign illegal_slot = st_q.illegal;

    // R4
    seq_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !slot_pending) |=> (next_pc == $past(issue_pc) + STEP));

    // R9
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !slot_pending && dec.links) |=>
            (link_we && link_data == $past(issue_pc) + STEP2));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_valid) |=> ($stable(next_pc) && $stable(slot_pending) && !link_we));

    // R11
    slot_xfer_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && slot_pending && dec.is_xfer) |=> (illegal_slot && !slot_pending));

    // R11
    no_link_when_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_slot |-> !link_we);

endmodule

// File: tb/dbr_next_pc_tb_top.sv
`timescale 1ns/1ps
module dbr_next_pc_tb_top;

    localparam logic [31:0] NOP_W = 32'h1500_0000; // class 0, sub 5, bits 25:24 = 1

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] insn;
        logic        flag;
        logic [31:0] ra;
        logic [31:0] exp_next;
        logic        exp_lwe;
        logic [31:0] exp_link;
    } vec_t;

    // R3 R4 R5 R6 R7 R8 R9 vectors: branch, then a slot issued at pc+4
    localparam vec_t VECS [11] = '{
        '{32'h0000_0100, 32'h0000_0400, 1'b0, 32'h0,         32'h0000_1000, 1'b0, 32'h0},          // R5 jump abs
        '{32'h0000_0200, 32'h0400_0800, 1'b0, 32'h0,         32'h0000_2000, 1'b1, 32'h0000_0208},  // R9 jal
        '{32'h0000_0300, 32'h0BFF_FFFC, 1'b0, 32'h0,         32'h0000_02F0, 1'b1, 32'h0000_0308},  // R6 negative
        '{32'h0000_0400, 32'h0C00_0010, 1'b0, 32'h0,         32'h0000_0440, 1'b0, 32'h0},          // R8 clr taken
        '{32'h0000_0400, 32'h0C00_0010, 1'b1, 32'h0,         32'h0000_0408, 1'b0, 32'h0},          // R8 clr not
        '{32'h0000_0500, 32'h1000_0010, 1'b1, 32'h0,         32'h0000_0540, 1'b0, 32'h0},          // R8 set taken
        '{32'h0000_0500, 32'h1000_0010, 1'b0, 32'h0,         32'h0000_0508, 1'b0, 32'h0},          // R8 set not
        '{32'h0000_0600, 32'h140B_0000, 1'b0, 32'h1234_5678, 32'h1234_5678, 1'b0, 32'h0},          // R7 jr
        '{32'h0000_0700, 32'h142B_0000, 1'b0, 32'hABCD_0000, 32'hABCD_0000, 1'b1, 32'h0000_0708},  // R7 jalr r11
        '{32'h0000_1000, 32'h0810_0000, 1'b0, 32'h0,         32'h0040_1000, 1'b1, 32'h0000_1008},  // R6 forward
        '{32'h8000_0000, 32'h03FF_FFFF, 1'b0, 32'h0,         32'h0FFF_FFFC, 1'b0, 32'h0}           // R5 zero-ext
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_pc = '0;
    logic [31:0] issue_insn = '0;
    logic        issue_flag = 1'b0;
    logic [31:0] ra_value = '0;
    logic [31:0] next_pc;
    logic        slot_pending;
    logic        link_we;
    logic [31:0] link_data;
    logic        illegal_slot;

    int n_total = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    dbr_next_pc dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_valid  (issue_valid),
        .issue_pc     (issue_pc),
        .issue_insn   (issue_insn),
        .issue_flag   (issue_flag),
        .ra_value     (ra_value),
        .next_pc      (next_pc),
        .slot_pending (slot_pending),
        .link_we      (link_we),
        .link_data    (link_data),
        .illegal_slot (illegal_slot)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] pc, input logic [31:0] insn,
                         input logic fl, input logic [31:0] ra);
        @(negedge clk);
        issue_valid = 1'b1;
        issue_pc    = pc;
        issue_insn  = insn;
        issue_flag  = fl;
        ra_value    = ra;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        n_total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 next_pc in reset", next_pc, 32'h0);
        chk("R1 slot in reset", {31'b0, slot_pending}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 next_pc after reset", next_pc, 32'h0);
        chk("R1 link_we after reset", {31'b0, link_we}, 32'h0);
        chk("R1 illegal after reset", {31'b0, illegal_slot}, 32'h0);

        // Vector walk
        foreach (VECS[i]) begin
            issue(VECS[i].pc, VECS[i].insn, VECS[i].flag, VECS[i].ra);
            chk($sformatf("R4 slot addr v%0d", i), next_pc, VECS[i].pc + 32'd4);
            chk($sformatf("R4 slot pending v%0d", i), {31'b0, slot_pending}, 32'h1);
            chk($sformatf("R9 link_we v%0d", i), {31'b0, link_we}, {31'b0, VECS[i].exp_lwe});
            if (VECS[i].exp_lwe)
                chk($sformatf("R9 link_data v%0d", i), link_data, VECS[i].exp_link);
            // flip flag and ra in the slot to prove they were sampled at the branch (R7 R8)
            issue(VECS[i].pc + 32'd4, NOP_W, ~VECS[i].flag, 32'hDEAD_0000);
            chk($sformatf("R4 target v%0d", i), next_pc, VECS[i].exp_next);
            chk($sformatf("R4 slot cleared v%0d", i), {31'b0, slot_pending}, 32'h0);
            chk($sformatf("R9 no link in slot v%0d", i), {31'b0, link_we}, 32'h0);
        end

        // R2 R3 non-transfer encodings
        issue(32'h0000_0900, 32'h8000_0000, 1'b0, 32'h0);
        chk("R2 other class next", next_pc, 32'h0000_0904);
        chk("R2 other class slot", {31'b0, slot_pending}, 32'h0);
        issue(32'h0000_0904, 32'h1440_0000, 1'b0, 32'h5555_0000);
        chk("R3 sub5 op 2 not xfer", {31'b0, slot_pending}, 32'h0);
        chk("R3 sub5 op 2 next", next_pc, 32'h0000_0908);
        issue(32'h0000_0908, 32'h1800_0000, 1'b0, 32'h0);
        chk("R3 sub6 not xfer", {31'b0, slot_pending}, 32'h0);
        chk("R3 sub6 no link", {31'b0, link_we}, 32'h0);

        // R10 stall between branch and slot
        issue(32'h0000_0A00, 32'h1000_0020, 1'b1, 32'h0); // flag-1 form, taken -> 0xA80
        @(negedge clk);
        issue_flag = 1'b0; ra_value = 32'hFFFF_FFFF; issue_insn = 32'h0000_0001; issue_pc = 32'h7;
        repeat (3) @(negedge clk);
        chk("R10 next held", next_pc, 32'h0000_0A04);
        chk("R10 slot held", {31'b0, slot_pending}, 32'h1);
        issue(32'h0000_0A04, NOP_W, 1'b0, 32'h0);
        chk("R10 target after stall", next_pc, 32'h0000_0A80);

        // R11 transfer placed in a delay slot
        issue(32'h0000_0800, 32'h0000_0400, 1'b0, 32'h0);       // jump abs -> 0x1000
        issue(32'h0000_0804, 32'h0400_0800, 1'b0, 32'h0);       // jal in slot
        chk("R11 illegal raised", {31'b0, illegal_slot}, 32'h1);
        chk("R11 no link", {31'b0, link_we}, 32'h0);
        chk("R11 first target kept", next_pc, 32'h0000_1000);
        chk("R11 slot cleared", {31'b0, slot_pending}, 32'h0);
        issue(32'h0000_1000, NOP_W, 1'b0, 32'h0);
        chk("R11 slot target ignored", next_pc, 32'h0000_1004);
        chk("R11 pulse ends", {31'b0, illegal_slot}, 32'h0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule